// File: doc/BRIEF.md
# Peripheral DMA Channel Controller

A single DMA channel that copies 32-bit words between a memory-side port and a peripheral-side port. Software sets it up through a control register, two pointer registers and a status register. It can run one transfer and stop (one-shot), or loop over a double buffer (continuous). In continuous mode the programmed count covers one half of the buffer. The channel raises an end-of-count event at every half and keeps going into the other half.

Words can be paced by a selected peripheral request line, or moved back to back. Loading the reserved selector value 31 parks a paced channel without clearing its enable. Software can then read the remaining count while the channel still reports busy. A master enable pin gates the whole channel.

Both data ports are valid/ready request channels. The channel raises valid with address, write flag and write data, and holds all of them unchanged until ready is seen high at a clock edge. For a read, the responder returns read data in the cycle where ready is high. The responder may hold ready low for as long as it needs. Each word is a read on the source port followed by a write on the destination port.

Top module: `pdma_channel`

## Requirements
- R1: A control write stores only the implemented bits: enable 31, interrupt enable 30, hold 29, direction 28, one-shot 27, flow 21, selector 20:16 and count 15:2. The other bits read as 0. A write that sets enable while it is clear starts the channel. The start loads the remaining count from the count field (words minus one, at most 16384 words), clears the ping-pong bit and copies both pointer registers into the active addresses.
- R2: Direction 1 moves data from memory to peripheral, and direction 0 moves data from peripheral to memory. Each word is read from the source port, and the same data is then written to the destination port. The memory address advances by 4 per word. The peripheral address stays fixed.
- R3: On either port, valid, the write flag, the address and the write data stay stable from the cycle valid rises until the cycle ready is high.
- R4: With flow off, words start back to back. With flow on, one word starts per rising edge of request line `preq[selector]`. Edges on lines that are not selected have no effect.
- R5: One-shot (bit 27 = 1): after count+1 words, the enable bit and busy clear and the pending bit sets.
- R6: Continuous (bit 27 = 0): after every count+1 words, the pending bit sets, the ping-pong bit toggles, the remaining count reloads and busy stays 1. After the first half the memory address continues. After the second half both active addresses reload from the pointer registers.
- R7: Status reads as follows: bit 31 busy (equals enable), bit 30 pending, bit 29 halted, bit 28 ping-pong, bits 15:2 remaining count (words left minus one). All other bits read 0.
- R8: A status write with bit 30 = 1 clears the pending bit. A status write with bit 30 = 0 changes nothing. A new end-of-count in the same cycle wins over the clear.
- R9: `irq` is high exactly when the pending bit and the interrupt enable are both 1.
- R10: With enable = 1, flow = 1 and selector = 31, the halted bit is 1, no new word starts and busy stays 1. Restoring a valid selector resumes the transfer.
- R11: While hold (bit 29) is 1, no new word starts. The halted bit stays 0.
- R12: While `glb_en` is 0, no new word starts.
- R13: The low two bits of a pointer write are ignored, so every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Master enable for the channel |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write value |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write value (bit 30 clears pending) |
| mptr_wr | input | 1 | Memory pointer register write strobe |
| pptr_wr | input | 1 | Peripheral pointer register write strobe |
| ptr_wdata | input | AW | Pointer write value |
| ctl_q | output | 32 | Control register readback |
| sts_q | output | 32 | Status register readback |
| irq | output | 1 | End-of-count interrupt |
| preq | input | NREQ | Peripheral request lines |
| mem_vld | output | 1 | Memory port request valid |
| mem_we | output | 1 | Memory port write flag |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | 32 | Memory port write data |
| mem_rdata | input | 32 | Memory port read data |
| mem_rdy | input | 1 | Memory port ready |
| per_vld | output | 1 | Peripheral port request valid |
| per_we | output | 1 | Peripheral port write flag |
| per_addr | output | AW | Peripheral port address |
| per_wdata | output | 32 | Peripheral port write data |
| per_rdata | input | 32 | Peripheral port read data |
| per_rdy | input | 1 | Peripheral port ready |

## Verification
The hardest state to reach is a paced channel parked with selector 31 part-way through a transfer. The channel must still be busy with a known nonzero remaining count. The bench reaches this state by issuing single request pulses and waiting for each word to land on the scoreboard. Only then does it rewrite the selector and pulse the former line, confirming that no word moves. The continuous case is paced the same way, one pulse per word. This lets the pointer register be rewritten between halves and the reload point be seen exactly. The buffer loops forever, so this pacing is also the only way to stop the channel between words.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int CNT_W   = 14;
  localparam int SEL_W   = 5;
  localparam int B_EN    = 31;
  localparam int B_IE    = 30;
  localparam int B_HOLD  = 29;
  localparam int B_DIR   = 28;
  localparam int B_ONCE  = 27;
  localparam int B_FLOW  = 21;
  localparam int SEL_LO  = 16;
  localparam int CNT_LO  = 2;
  localparam int B_PEND  = 30;
  localparam logic [SEL_W-1:0] SEL_OFF = '1;
  localparam logic [31:0] CTL_MASK = 32'hF83F_FFFC;

  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_t;
endpackage

// File: rtl/pdma_pace.sv
module pdma_pace #(
  parameter int NREQ = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req,
  input  logic [pdma_pkg::SEL_W-1:0] sel,
  input  logic                     clr,
  input  logic                     take,
  output logic                     credit
);
  logic line, prev, rise;

  always_comb begin
    line = 1'b0;
    for (int i = 0; i < NREQ; i++)
      if (int'(sel) == i) line = req[i];
  end

  assign rise = line & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      credit <= 1'b0;
    end else begin
      prev <= line;
      if (clr)       credit <= 1'b0;
      else if (rise) credit <= 1'b1;
      else if (take) credit <= 1'b0;
    end
  end

  // R4
  take_has_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> credit);
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
  import pdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        dir,
  input  logic        mem_rdy,
  input  logic [31:0] mem_rdata,
  input  logic        per_rdy,
  input  logic [31:0] per_rdata,
  output logic        mem_vld,
  output logic        mem_we,
  output logic        per_vld,
  output logic        per_we,
  output logic [31:0] wdata,
  output logic        accept,
  output logic        done,
  output logic        active
);
  mv_state_t st;
  logic dir_q;
  logic src_rdy, dst_rdy;

  assign src_rdy = dir_q ? mem_rdy : per_rdy;
  assign dst_rdy = dir_q ? per_rdy : mem_rdy;
  assign accept  = (st == MV_IDLE) && go;
  assign done    = (st == MV_WRITE) && dst_rdy;
  assign active  = (st != MV_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= MV_IDLE;
      dir_q <= 1'b0;
      wdata <= '0;
    end else begin
      case (st)
        MV_IDLE:  if (go) begin dir_q <= dir; st <= MV_READ; end
        MV_READ:  if (src_rdy) begin
                    wdata <= dir_q ? mem_rdata : per_rdata;
                    st    <= MV_WRITE;
                  end
        MV_WRITE: if (dst_rdy) st <= MV_IDLE;
        default:  st <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_vld = ((st == MV_READ) && dir_q) || ((st == MV_WRITE) && !dir_q);
    mem_we  = (st == MV_WRITE) && !dir_q;
    per_vld = ((st == MV_READ) && !dir_q) || ((st == MV_WRITE) && dir_q);
    per_we  = (st == MV_WRITE) && dir_q;
  end

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld && !mem_rdy |=> mem_vld && $stable(mem_we) && $stable(wdata));
  // R3
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_vld && !per_rdy |=> per_vld && $stable(per_we) && $stable(wdata));
  // R2
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_vld, per_vld}));
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int NREQ = 31,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glb_en,
  input  logic            ctl_wr,
  input  logic [31:0]     ctl_wdata,
  input  logic            sts_wr,
  input  logic [31:0]     sts_wdata,
  input  logic            mptr_wr,
  input  logic            pptr_wr,
  input  logic [AW-1:0]   ptr_wdata,
  output logic [31:0]     ctl_q,
  output logic [31:0]     sts_q,
  output logic            irq,
  input  logic [NREQ-1:0] preq,
  output logic            mem_vld,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_rdy,
  output logic            per_vld,
  output logic            per_we,
  output logic [AW-1:0]   per_addr,
  output logic [31:0]     per_wdata,
  input  logic [31:0]     per_rdata,
  input  logic            per_rdy
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [31:0]      ctl_r;
  logic [CNT_W-1:0] rem;
  logic             ping, pend;
  logic [AW-1:0]    m_shadow, p_shadow, m_cur, p_cur;
  logic             en, ie, hold, dir, once, flow;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] wcnt;
  logic             start, halted, go, take, last, wd, credit;
  logic             accept, done, mv_active;
  logic [31:0]      mv_wdata;
  logic             unused_bits;

  assign en   = ctl_r[B_EN];
  assign ie   = ctl_r[B_IE];
  assign hold = ctl_r[B_HOLD];
  assign dir  = ctl_r[B_DIR];
  assign once = ctl_r[B_ONCE];
  assign flow = ctl_r[B_FLOW];
  assign sel  = ctl_r[SEL_LO +: SEL_W];
  assign wcnt = ctl_r[CNT_LO +: CNT_W];
  assign unused_bits = ^{sts_wdata[31], sts_wdata[29:0], ptr_wdata[1:0]};

  assign start  = ctl_wr && ctl_wdata[B_EN] && !en;
  assign halted = en && flow && (sel == SEL_OFF);
  assign go     = en && glb_en && !hold && (!flow || (credit && !halted));
  assign take   = accept && flow;
  assign last   = (rem == '0);
  assign wd     = done && en;

  pdma_pace #(.NREQ(NREQ)) u_pace (
    .clk(clk), .rst_n(rst_n), .req(preq), .sel(sel),
    .clr(start), .take(take), .credit(credit));

  pdma_mover u_mover (
    .clk(clk), .rst_n(rst_n), .go(go), .dir(dir),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .per_rdy(per_rdy), .per_rdata(per_rdata),
    .mem_vld(mem_vld), .mem_we(mem_we),
    .per_vld(per_vld), .per_we(per_we),
    .wdata(mv_wdata), .accept(accept), .done(done), .active(mv_active));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r    <= '0;
      rem      <= '0;
      ping     <= 1'b0;
      pend     <= 1'b0;
      m_shadow <= '0;
      p_shadow <= '0;
      m_cur    <= '0;
      p_cur    <= '0;
    end else begin
      if (mptr_wr) m_shadow <= {ptr_wdata[AW-1:2], 2'b00};
      if (pptr_wr) p_shadow <= {ptr_wdata[AW-1:2], 2'b00};

      if (ctl_wr)                 ctl_r <= ctl_wdata & CTL_MASK;
      else if (wd && last && once) ctl_r[B_EN] <= 1'b0;

      if (wd && last)                     pend <= 1'b1;
      else if (sts_wr && sts_wdata[B_PEND]) pend <= 1'b0;

      if (start) begin
        rem   <= ctl_wdata[CNT_LO +: CNT_W];
        ping  <= 1'b0;
        m_cur <= m_shadow;
        p_cur <= p_shadow;
      end else if (wd) begin
        if (!last) begin
          rem   <= rem - 1'b1;
          m_cur <= m_cur + STEP;
        end else if (!once) begin
          rem  <= wcnt;
          ping <= ~ping;
          if (ping) begin
            m_cur <= m_shadow;
            p_cur <= p_shadow;
          end else begin
            m_cur <= m_cur + STEP;
          end
        end
      end
    end
  end

  assign ctl_q     = ctl_r;
  assign sts_q     = {en, pend, halted, ping, 12'b0, rem, 2'b00};
  assign irq       = pend && ie;
  assign mem_addr  = m_cur;
  assign per_addr  = p_cur;
  assign mem_wdata = mv_wdata;
  assign per_wdata = mv_wdata;

  // R3
  mem_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld && !mem_rdy |=> $stable(mem_addr));
  // R5
  once_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && once && wd && last && !ctl_wr |=> !ctl_q[B_EN] && sts_q[B_PEND]);
  // R6
  cont_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !once && wd && last && !ctl_wr |=> ctl_q[B_EN] && sts_q[B_PEND]);
  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && sts_wdata[B_PEND] && !(wd && last) |=> !sts_q[B_PEND]);
  // R10
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !mv_active |=> !mv_active);
  // R12
  glb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en && !mv_active |=> !mv_active);
endmodule

// File: tb/pdma_channel_test.sv
`timescale 1ns/1ps
module pdma_channel_test;
  localparam int NREQ = 31;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0, glb_en = 1;
  logic ctl_wr = 0, sts_wr = 0, mptr_wr = 0, pptr_wr = 0;
  logic [31:0] ctl_wdata = 0, sts_wdata = 0;
  logic [AW-1:0] ptr_wdata = 0;
  logic [31:0] ctl_q, sts_q;
  logic irq;
  logic [NREQ-1:0] preq = '0;
  logic mem_vld, mem_we, mem_rdy, per_vld, per_we, per_rdy;
  logic [AW-1:0] mem_addr, per_addr;
  logic [31:0] mem_wdata, mem_rdata, per_wdata, per_rdata;

  int cyc = 0, nchk = 0, nfail = 0, nwr = 0, per_rd_cnt = 0, exp_pidx = 0;
  logic [64:0] sb[$];

  always #2.5 clk = ~clk;

  pdma_channel #(.NREQ(NREQ), .AW(AW)) uut (.*);

  assign mem_rdy   = (cyc % 3) != 2;
  assign per_rdy   = (cyc % 4) != 1;
  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;
  assign per_rdata = 32'hC0DE_0000 | per_rd_cnt;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (per_vld && per_rdy && !per_we) per_rd_cnt <= per_rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes as the destination port completes them
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_vld && mem_we && mem_rdy) begin
        if (sb.size() == 0) chk(0, "R2 unexpected memory write", {1'b0, mem_addr, mem_wdata}, 0);
        else begin
          logic [64:0] e;
          e = sb.pop_front();
          chk(e == {1'b0, mem_addr, mem_wdata}, "R2 R3 memory write", {1'b0, mem_addr, mem_wdata}, e);
        end
        nwr++;
      end
      if (per_vld && per_we && per_rdy) begin
        if (sb.size() == 0) chk(0, "R2 unexpected peripheral write", {1'b1, per_addr, per_wdata}, 0);
        else begin
          logic [64:0] e;
          e = sb.pop_front();
          chk(e == {1'b1, per_addr, per_wdata}, "R2 R3 peripheral write", {1'b1, per_addr, per_wdata}, e);
        end
        nwr++;
      end
    end
  end

  function automatic logic [31:0] mk(bit en, bit ie, bit hold, bit dir, bit once, bit flow,
                                     logic [4:0] sel, logic [13:0] wc);
    return {en, ie, hold, dir, once, 5'b0, flow, sel, wc, 2'b00};
  endfunction

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1; @(negedge clk); ctl_wr = 0;
  endtask
  task automatic wr_sts(input logic [31:0] v);
    @(negedge clk); sts_wdata = v; sts_wr = 1; @(negedge clk); sts_wr = 0;
  endtask
  task automatic wr_mptr(input logic [31:0] v);
    @(negedge clk); ptr_wdata = v; mptr_wr = 1; @(negedge clk); mptr_wr = 0;
  endtask
  task automatic wr_pptr(input logic [31:0] v);
    @(negedge clk); ptr_wdata = v; pptr_wr = 1; @(negedge clk); pptr_wr = 0;
  endtask

  task automatic push_m2p(input logic [31:0] ma, input logic [31:0] pa, input int n);
    for (int i = 0; i < n; i++) sb.push_back({1'b1, pa, (ma + 32'(4*i)) ^ 32'h5A5A_0000});
  endtask
  task automatic push_p2m(input logic [31:0] ma, input int n);
    for (int i = 0; i < n; i++) begin
      sb.push_back({1'b0, ma + 32'(4*i), 32'hC0DE_0000 | exp_pidx});
      exp_pidx++;
    end
  endtask

  task automatic wait_writes(input int target, input string tag);
    int k = 0;
    while (nwr < target && k < 3000) begin @(negedge clk); k++; end
    chk(nwr >= target, tag, 65'(nwr), 65'(target));
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int line);
    @(negedge clk); preq[line] = 1; @(negedge clk); preq[line] = 0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R7 reset state
    chk(ctl_q == 0 && sts_q == 0 && !irq && !mem_vld && !per_vld, "R1 R7 reset", {ctl_q, sts_q}, 0);

    // R1 only implemented bits stored
    wr_ctl(32'h7FFF_FFFF);
    chk(ctl_q == 32'h783F_FFFC, "R1 control mask", 65'(ctl_q), 65'h783F_FFFC);
    wr_ctl(0);

    // R2 R5 R9 one-shot memory to peripheral, flow off
    wr_mptr(32'h1000); wr_pptr(32'h40);
    push_m2p(32'h1000, 32'h40, 4);
    base = nwr;
    wr_ctl(mk(1, 1, 0, 1, 1, 0, 5'd0, 14'd3));
    wait_writes(base + 4, "R2 one-shot words");
    chk(sts_q[31] == 0 && ctl_q[31] == 0, "R5 enable clears", 65'(sts_q), 0);
    chk(sts_q[30] == 1 && sts_q[15:2] == 0, "R5 pending and count", 65'(sts_q), 65'h4000_0000);
    chk(irq == 1, "R9 irq with enable", 65'(irq), 1);

    // R8 write without bit 30 ignored, then clear
    wr_sts(32'hBFFF_FFFF);
    chk(sts_q[30] == 1, "R8 write without clear bit", 65'(sts_q[30]), 1);
    wr_sts(32'h4000_0000);
    chk(sts_q[30] == 0 && irq == 0, "R8 pending cleared", 65'({sts_q[30], irq}), 0);

    // R13 R2 peripheral to memory, unaligned pointer
    wr_mptr(32'h2003); wr_pptr(32'h50);
    push_p2m(32'h2000, 2);
    base = nwr;
    wr_ctl(mk(1, 0, 0, 0, 1, 0, 5'd0, 14'd1));
    wait_writes(base + 2, "R13 R2 aligned peripheral-to-memory");
    chk(sts_q[31] == 0 && irq == 0, "R9 irq masked when ie off", 65'({sts_q[31], irq}), 0);
    wr_sts(32'h4000_0000);

    // R4 flow control on line 5
    wr_mptr(32'h1100); wr_pptr(32'h60);
    push_m2p(32'h1100, 32'h60, 3);
    base = nwr;
    wr_ctl(mk(1, 0, 0, 1, 1, 1, 5'd5, 14'd2));
    repeat (20) @(negedge clk);
    chk(nwr == base, "R4 no request no word", 65'(nwr), 65'(base));
    pulse(5);
    wait_writes(base + 1, "R4 one word per edge");
    repeat (10) @(negedge clk);
    chk(nwr == base + 1, "R4 single word only", 65'(nwr), 65'(base + 1));
    pulse(6);
    repeat (20) @(negedge clk);
    chk(nwr == base + 1, "R4 unselected line ignored", 65'(nwr), 65'(base + 1));
    pulse(5); wait_writes(base + 2, "R4 second edge");
    pulse(5); wait_writes(base + 3, "R4 third edge");
    chk(sts_q[31] == 0, "R5 flow one-shot ends", 65'(sts_q[31]), 0);
    wr_sts(32'h4000_0000);

    // R10 halt via selector 31
    wr_mptr(32'h1200); wr_pptr(32'h70);
    push_m2p(32'h1200, 32'h70, 6);
    base = nwr;
    wr_ctl(mk(1, 0, 0, 1, 1, 1, 5'd7, 14'd5));
    pulse(7); wait_writes(base + 1, "R10 pre-halt word 1");
    pulse(7); wait_writes(base + 2, "R10 pre-halt word 2");
    wr_ctl(mk(1, 0, 0, 1, 1, 1, 5'd31, 14'd5));
    pulse(7);
    repeat (20) @(negedge clk);
    chk(nwr == base + 2, "R10 no word while halted", 65'(nwr), 65'(base + 2));
    chk(sts_q[31] && sts_q[29] && sts_q[15:2] == 3, "R10 busy halted count", 65'(sts_q), 65'hA000_000C);
    wr_ctl(mk(1, 0, 0, 1, 1, 1, 5'd7, 14'd5));
    chk(sts_q[29] == 0, "R10 halt released", 65'(sts_q[29]), 0);
    for (int i = 3; i <= 6; i++) begin pulse(7); wait_writes(base + i, "R10 resumed word"); end
    chk(sts_q[31] == 0 && sts_q[30] == 1, "R10 finishes after resume", 65'(sts_q), 65'h4000_0000);
    wr_sts(32'h4000_0000);

    // R11 hold pauses without halted flag; R1 count loaded at start
    wr_mptr(32'h4000); wr_pptr(32'h44);
    push_m2p(32'h4000, 32'h44, 2);
    base = nwr;
    wr_ctl(mk(1, 0, 1, 1, 1, 0, 5'd0, 14'd1));
    repeat (20) @(negedge clk);
    chk(nwr == base, "R11 no word on hold", 65'(nwr), 65'(base));
    chk(sts_q[31] && !sts_q[29] && sts_q[15:2] == 1, "R11 R1 busy not halted count", 65'(sts_q), 65'h8000_0004);
    wr_ctl(mk(1, 0, 0, 1, 1, 0, 5'd0, 14'd1));
    wait_writes(base + 2, "R11 resumes after hold");
    wr_sts(32'h4000_0000);

    // R12 master enable
    glb_en = 0;
    wr_mptr(32'h4100);
    push_m2p(32'h4100, 32'h44, 2);
    base = nwr;
    wr_ctl(mk(1, 0, 0, 1, 1, 0, 5'd0, 14'd1));
    repeat (20) @(negedge clk);
    chk(nwr == base && sts_q[31], "R12 no word without master enable", 65'(nwr), 65'(base));
    glb_en = 1;
    wait_writes(base + 2, "R12 runs with master enable");
    wr_sts(32'h4000_0000);

    // R6 continuous double buffer, paced on line 2
    wr_mptr(32'h3000); wr_pptr(32'h80);
    push_p2m(32'h3000, 4);
    push_p2m(32'h5000, 2);
    base = nwr;
    wr_ctl(mk(1, 1, 0, 0, 0, 1, 5'd2, 14'd1));
    pulse(2); wait_writes(base + 1, "R6 half1 w1");
    pulse(2); wait_writes(base + 2, "R6 half1 w2");
    chk(sts_q[31] && sts_q[30] && sts_q[28] && sts_q[15:2] == 1, "R6 first half", 65'(sts_q), 65'hD000_0004);
    chk(irq == 1, "R9 irq in continuous", 65'(irq), 1);
    wr_sts(32'h4000_0000);
    wr_mptr(32'h5000);
    pulse(2); wait_writes(base + 3, "R6 half2 w1");
    pulse(2); wait_writes(base + 4, "R6 half2 w2");
    chk(sts_q[31] && sts_q[30] && !sts_q[28], "R6 second half", 65'(sts_q), 65'hC000_0004);
    wr_sts(32'h4000_0000);
    wr_ctl(mk(1, 0, 0, 0, 0, 1, 5'd2, 14'd1));
    pulse(2); wait_writes(base + 5, "R6 reload w1");
    pulse(2); wait_writes(base + 6, "R6 reload w2");
    chk(sts_q[30] && sts_q[28] && irq == 0, "R9 R6 pending masked", 65'({sts_q[30], sts_q[28], irq}), 65'b110);
    wr_ctl(0);
    chk(sts_q[31] == 0, "R7 busy follows enable", 65'(sts_q[31]), 0);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R2 all expected writes seen", 65'(sb.size()), 0);
    finish_run();
  end
endmodule